// File: doc/BRIEF.md
# Carry-Less Multiplier Unit

This block is a bit-serial coprocessor that forms the carry-less product of two operands for a small 32-bit processor. In a carry-less product the operands are treated as polynomials over GF(2). Each partial product is merged into the running sum with exclusive OR, so no carry ever moves between bit positions. The processor presents an operation code, two source register values and a valid strobe. A set number of cycles later, the unit returns one destination word with a single-cycle ready pulse.

Three views of the double-width product can be returned: its lower word, its upper word, or a window shifted down by one from the upper word, which is the bit-reversed form. Placing the low-word and high-word results side by side gives the whole double-width product. The unit takes one multiplier bit per cycle. Any request that arrives while a product is still being formed is dropped.

The operand width is the parameter `W`, which defaults to 32.

Top module: `clmul_unit`

## Requirements
- R1: While reset is held and after it is released, `busy` and `rsp_ready` are 0 and `rsp_data` is 0.
- R2: A request is accepted on a rising clock edge where `req_valid` is 1 and `busy` is 0. After that edge, `busy` reads 1.
- R3: `rsp_ready` goes to 1 for exactly one cycle, W clock edges after the accepting edge. `busy` returns to 0 on the same edge.
- R4: `req_op` = 2'b00 returns bits W-1..0 of the carry-less product, where the partial products are combined by exclusive OR.
- R5: `req_op` = 2'b01 returns bits 2W-1..W of the product. Bit W-1 of this result is always 0. Together with the R4 result, it forms the full 2W-bit product.
- R6: `req_op` = 2'b10 returns bits 2W-2..W-1 of the product, which is the reversed form.
- R7: `req_op` = 2'b11 gives the same result as 2'b00.
- R8: A request presented while `busy` is 1 is ignored. The result, operation and timing of the product in flight do not change.
- R9: `rsp_data` keeps its last value in every cycle where `rsp_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 00 low word, 01 high word, 10 reversed, 11 low word |
| req_a | input | W | First operand (multiplier) |
| req_b | input | W | Second operand (multiplicand) |
| busy | output | 1 | A product is being formed |
| rsp_ready | output | 1 | One-cycle pulse: `rsp_data` holds a new result |
| rsp_data | output | W | Selected word of the product |

## Verification
The assertions assume that `req_op` and the operands are sampled only on an accepting edge. They also assume the requester can raise `req_valid` at any time, including while `busy` is 1. The latency and high-word checks follow only the requests they see accepted at the ports. The stimulus therefore holds `req_valid` for exactly one edge when the unit is idle, and also injects requests with altered operands and opcodes in the middle of a product to exercise the dropped case. A four-bit instance is swept over every operand pair and every opcode, and a full-width instance runs known polynomial vectors.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  typedef enum logic [1:0] {
    OP_LO  = 2'b00,
    OP_HI  = 2'b01,
    OP_REV = 2'b10,
    OP_ALT = 2'b11
  } clmul_op_e;
endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic busy_o,
  output logic load_en_o,
  output logic step_en_o,
  output logic last_o,
  output logic done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;

  assign load_en_o = start_req & ~busy_q;
  assign step_en_o = busy_q;
  assign last_o    = busy_q & (cnt_q == LAST_CNT);

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    done_n = last_o;
    if (load_en_o) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (step_en_o) begin
      cnt_n = cnt_q + 1'b1;
      if (last_o) begin
        busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/clmul_datapath.sv
module clmul_datapath #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic           step_en,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  output logic [2*W-1:0] prod_next_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc_q, acc_n;
  logic [PW-1:0] mcand_q, mcand_n;
  logic [W-1:0]  mplier_q, mplier_n;
  logic [PW-1:0] term;

  for (genvar i = 0; i < PW; i++) begin : g_term
    assign term[i] = mcand_q[i] & mplier_q[0];
  end

  assign prod_next_o = acc_q ^ term;

  always_comb begin
    acc_n    = acc_q;
    mcand_n  = mcand_q;
    mplier_n = mplier_q;
    if (load_en) begin
      acc_n    = '0;
      mcand_n  = {{W{1'b0}}, opb_i};
      mplier_n = opa_i;
    end else if (step_en) begin
      acc_n    = prod_next_o;
      mcand_n  = {mcand_q[PW-2:0], 1'b0};
      mplier_n = {1'b0, mplier_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else begin
      acc_q    <= acc_n;
      mcand_q  <= mcand_n;
      mplier_q <= mplier_n;
    end
  end
endmodule

// File: rtl/clmul_select.sv
module clmul_select
  import clmul_pkg::*;
#(
  parameter int W = 32
) (
  input  clmul_op_e      op_i,
  input  logic [2*W-1:0] prod_i,
  output logic [W-1:0]   res_o
);
  always_comb begin
    unique case (op_i)
      OP_HI:   res_o = prod_i[2*W-1:W];
      OP_REV:  res_o = prod_i[2*W-2:W-1];
      default: res_o = prod_i[W-1:0];
    endcase
  end
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
  import clmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  output logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  logic           load_en, step_en, last_step, done;
  logic [2*W-1:0] prod_next;
  logic [W-1:0]   sel_res;
  clmul_op_e      op_q, op_n;
  logic [W-1:0]   data_q, data_n;

  clmul_ctrl #(.W(W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (req_valid),
    .busy_o    (busy),
    .load_en_o (load_en),
    .step_en_o (step_en),
    .last_o    (last_step),
    .done_o    (done)
  );

  clmul_datapath #(.W(W)) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .step_en     (step_en),
    .opa_i       (req_a),
    .opb_i       (req_b),
    .prod_next_o (prod_next)
  );

  clmul_select #(.W(W)) i_sel (
    .op_i   (op_q),
    .prod_i (prod_next),
    .res_o  (sel_res)
  );

  always_comb begin
    op_n   = load_en ? clmul_op_e'(req_op) : op_q;
    data_n = last_step ? sel_res : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_LO;
      data_q <= '0;
    end else begin
      op_q   <= op_n;
      data_q <= data_n;
    end
  end

  assign rsp_ready = done;
  assign rsp_data  = data_q;
endmodule

// File: rtl/clmul_unit_chk.sv
module clmul_unit_chk
  import clmul_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [1:0]   req_op,
  input logic         busy,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_data
);
  logic [15:0] lat_q;
  logic [1:0]  op_cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q    <= '0;
      op_cap_q <= 2'b00;
    end else if (req_valid && !busy) begin
      lat_q    <= '0;
      op_cap_q <= req_op;
    end else if (busy) begin
      lat_q <= lat_q + 16'd1;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R3
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_ready);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (lat_q == 16'(W)));

  // R5
  hi_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && op_cap_q == OP_HI) |-> !rsp_data[W-1]);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |-> $stable(rsp_data));
endmodule

bind clmul_unit clmul_unit_chk #(.W(W)) i_clmul_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .busy      (busy),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/test_clmul_unit.sv
module test_clmul_unit;
  logic        clk;
  logic        rst_n;
  logic        v_s, v_l;
  logic [1:0]  op_i;
  logic [31:0] a_i, b_i;
  logic        busy_s, rdy_s, busy_l, rdy_l;
  logic [3:0]  dat_s;
  logic [31:0] dat_l;
  int          n_checks, n_fail, cyc;
  bit          done_flag;

  clmul_unit #(.W(4)) i_clmul_unit (
    .clk (clk), .rst_n (rst_n), .req_valid (v_s), .req_op (op_i),
    .req_a (a_i[3:0]), .req_b (b_i[3:0]),
    .busy (busy_s), .rsp_ready (rdy_s), .rsp_data (dat_s)
  );

  clmul_unit #(.W(32)) i_clmul_unit_w32 (
    .clk (clk), .rst_n (rst_n), .req_valid (v_l), .req_op (op_i),
    .req_a (a_i), .req_b (b_i),
    .busy (busy_l), .rsp_ready (rdy_l), .rsp_data (dat_l)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] cl_ref(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [63:0] p = '0;
    logic [63:0] m = (64'h1 << w) - 64'h1;
    for (int i = 0; i < w; i++)
      if (a[i]) p = p ^ (({32'b0, b} & m) << i);
    return p;
  endfunction

  function automatic logic [31:0] want(input logic [1:0] op, input logic [31:0] a,
                                       input logic [31:0] b, input int w);
    logic [63:0] p = cl_ref(a, b, w);
    logic [63:0] m = (64'h1 << w) - 64'h1;
    case (op)
      2'b01:   return 32'((p >> w) & m);
      2'b10:   return 32'((p >> (w - 1)) & m);
      default: return 32'(p & m);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit big, input logic [1:0] op, input logic [31:0] a,
                     input logic [31:0] b, input bit intr);
    int w = big ? 32 : 4;
    logic [31:0] exp = want(op, a, b, w);
    logic [31:0] got;
    int lat = 0;
    bit seen = 0;
    string rq = (op == 2'b01) ? "R5" : (op == 2'b10) ? "R6" : (op == 2'b11) ? "R7" : "R4";
    @(negedge clk);
    op_i = op; a_i = a; b_i = b;
    if (big) v_l = 1'b1; else v_s = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v_l = 1'b0; v_s = 1'b0;
    chk((big ? busy_l : busy_s) == 1'b1, "R2", "busy after accept", 64'(big ? busy_l : busy_s), 64'd1);
    while (!seen && lat < 2 * w + 4) begin
      if (intr && lat == 1) begin
        a_i = ~a; b_i = b ^ 32'h5; op_i = op ^ 2'b01;
        if (big) v_l = 1'b1; else v_s = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      v_l = 1'b0; v_s = 1'b0;
      lat++;
      seen = big ? rdy_l : rdy_s;
    end
    got = big ? dat_l : {28'b0, dat_s};
    chk(seen && lat == w, intr ? "R8" : "R3", "latency", 64'(lat), 64'(w));
    chk(got == exp, intr ? "R8" : rq, "result", 64'(got), 64'(exp));
    if (op == 2'b01) chk(got[w-1] == 1'b0, "R5", "high msb", 64'(got[w-1]), 64'd0);
    @(negedge clk);
    chk((big ? rdy_l : rdy_s) == 1'b0 && (big ? busy_l : busy_s) == 1'b0, "R3",
        "pulse one cycle", 64'(big ? rdy_l : rdy_s), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done_flag) begin
      done_flag = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    n_checks = 0; n_fail = 0; cyc = 0; done_flag = 1'b0;
    rst_n = 1'b0; v_s = 1'b0; v_l = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy_s && !rdy_s && dat_s == 4'h0, "R1", "small in reset", 64'(dat_s), 64'd0);
    chk(!busy_l && !rdy_l && dat_l == 32'h0, "R1", "wide in reset", 64'(dat_l), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_l && !rdy_l && dat_l == 32'h0, "R1", "after release", 64'(dat_l), 64'd0);

    // R4 R5 R6 R7 exhaustive on the four-bit instance
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run(1'b0, 2'(op), 32'(a), 32'(b), 1'b0);

    // Known polynomial: (x^31+1)^2 = x^62+1
    run(1'b1, 2'b00, 32'h8000_0001, 32'h8000_0001, 1'b0);
    chk(dat_l == 32'h0000_0001, "R4", "square low", 64'(dat_l), 64'h1);
    run(1'b1, 2'b01, 32'h8000_0001, 32'h8000_0001, 1'b0);
    chk(dat_l == 32'h4000_0000, "R5", "square high", 64'(dat_l), 64'h4000_0000);
    run(1'b1, 2'b10, 32'h8000_0001, 32'h8000_0001, 1'b0);
    chk(dat_l == 32'h8000_0000, "R6", "square reversed", 64'(dat_l), 64'h8000_0000);
    for (int op = 0; op < 4; op++) begin
      run(1'b1, 2'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run(1'b1, 2'(op), 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b0);
      run(1'b1, 2'(op), 32'h0000_0000, 32'hA5A5_A5A5, 1'b0);
    end

    // R8 requests while busy are ignored
    for (int op = 0; op < 3; op++) begin
      run(1'b1, 2'(op), 32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
      run(1'b0, 2'(op), 32'h0000_000B, 32'h0000_0006, 1'b1);
    end

    // R9 output holds after the pulse
    held = dat_l;
    repeat (5) @(negedge clk);
    chk(dat_l == held && !rdy_l, "R9", "hold", 64'(dat_l), 64'(held));

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule